// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block is the part of an 8-bit processor core that carries it from a reset, a software break opcode, a maskable interrupt or a non-maskable interrupt into the matching handler. Each entry takes seven clock cycles and makes exactly one bus access per cycle. The block drives the address, the read and write strobes and the write data for each access, and captures the handler address from the vector bytes it reads back. It holds the program counter, the stack pointer and the processor flags that these entries change. The rest of the core can load the program counter and the flags while the block is idle.

The core marks each instruction boundary with `insn_boundary`. At such a boundary a pending non-maskable request wins, then an enabled maskable request. A `brk_start` strobe begins a software break when no interrupt is taken in the same cycle. A non-maskable request that arrives before the flags are pushed redirects a break or maskable entry to its own vector. A request that arrives during the two vector reads changes nothing in the entry under way. In the single instruction fetch that follows a maskable entry, a waiting non-maskable request is held off. `seq_done` is high in the seventh cycle, and the core resumes opcode fetch in the next cycle.

Top module: `vec_entry_seq`

## Requirements
- R1: An entry runs for exactly seven cycles. Each of those cycles asserts exactly one of `bus_rd` or `bus_wr`, and `seq_done` is high only in the seventh. While idle, neither strobe is asserted.
- R2: While `rst` is high the PC is 0x0000, the SP is 0x00 and `status_out` reads 0x20. After release the reset entry reads the PC twice, then reads 0x0100, 0x01FF and 0x01FE, lowering the SP after each read. It makes no write, and it ends with the SP at 0xFD.
- R3: Each entry reads its vector low byte in cycle six and its high byte in cycle seven, then loads PC = {high, low}. Reset uses 0xFFFC/0xFFFD, the non-maskable entry 0xFFFA/0xFFFB, and the maskable and break entries both use 0xFFFE/0xFFFF.
- R4: A break entry reads at PC and then at PC+1, advancing the PC after each read. It then writes PC[15:8], PC[7:0] and the flags byte with bit 4 set, in that order, each to 0x0100+SP, and the SP drops by one after each write.
- R5: A maskable or non-maskable entry reads twice at the unchanged PC. It then pushes PC high, PC low and the flags byte with bit 4 clear in the same way as R4.
- R6: The interrupt-disable flag (bit 2) is unchanged up to and including cycle six and is set after cycle seven. This holds for every kind of entry.
- R7: If a non-maskable request becomes pending by the flag-push cycle (cycle five) of a break or maskable entry, that entry fetches 0xFFFA/0xFFFB and clears the pending request. The pushed bit 4 still follows the original entry kind.
- R8: A non-maskable edge during cycle six or seven leaves the vector reads unchanged. The request stays pending and is taken at a later boundary.
- R9: At the first boundary after a maskable entry completes, a pending non-maskable request is not taken. It is taken at the boundary after that.
- R10: The non-maskable input acts on rising edges. A level held high after its entry has completed starts no further entry.
- R11: The maskable input is level-sensitive and is taken at a boundary only while bit 2 of the flags is clear.
- R12: At a boundary, a non-maskable request wins over a maskable one, and both win over `brk_start`. Raising `rst` during any entry restarts the reset entry from its first cycle.
- R13: While idle, `pc_load` loads `pc_in`, and `status_load` loads bits 7, 6, 3, 2, 1 and 0 of `status_in`. `status_out` always shows bit 5 as one and bit 4 as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts the reset entry |
| insn_boundary | input | 1 | Instruction boundary where interrupts may be taken |
| brk_start | input | 1 | Starts a software break entry |
| irq_lvl | input | 1 | Maskable interrupt request, active high, level |
| nmi_lvl | input | 1 | Non-maskable interrupt request, active high, edge |
| pc_load | input | 1 | Load program counter while idle |
| pc_in | input | 16 | Program counter load value |
| status_load | input | 1 | Load flags while idle |
| status_in | input | 8 | Flags load value |
| rd_data | input | 8 | Bus read data |
| bus_addr | output | 16 | Bus address of this cycle |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| seq_done | output | 1 | High in the last cycle of an entry |
| seq_busy | output | 1 | An entry is in progress |
| pc_out | output | 16 | Program counter |
| sp_out | output | 8 | Stack pointer |
| status_out | output | 8 | Flags byte |

## Verification
The assertions assume that `rd_data` is valid in the same cycle as the vector read strobe. They also assume that `rst` is released only on a clock edge, and that the core pulses `insn_boundary` or `brk_start` only while `seq_busy` is low. The bench returns read data from a combinational memory model addressed by `bus_addr`. It raises the boundary and break strobes for one cycle, and only in idle cycles. It changes `nmi_lvl` only after a clock edge, at a chosen cycle of an entry, so that each redirect or non-redirect case lands in a known cycle.

// File: rtl/ves_pkg.sv
package ves_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    localparam byte_t STACK_PAGE = 8'h01;
    localparam byte_t VEC_PAGE   = 8'hFF;
    localparam byte_t VEC_NMI_LO = 8'hFA;
    localparam byte_t VEC_RST_LO = 8'hFC;
    localparam byte_t VEC_IRQ_LO = 8'hFE;

    // bit positions of the flags byte
    localparam int P_N   = 7;
    localparam int P_V   = 6;
    localparam int P_ONE = 5;
    localparam int P_B   = 4;
    localparam int P_D   = 3;
    localparam int P_I   = 2;
    localparam int P_Z   = 1;
    localparam int P_C   = 0;

    typedef enum logic [1:0] {
        K_RST = 2'd0,
        K_BRK = 2'd1,
        K_IRQ = 2'd2,
        K_NMI = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_FETCH   = 3'd1,
        S_PAD     = 3'd2,
        S_PUSH_HI = 3'd3,
        S_PUSH_LO = 3'd4,
        S_PUSH_P  = 3'd5,
        S_VEC_LO  = 3'd6,
        S_VEC_HI  = 3'd7
    } step_e;

    typedef struct packed {
        logic n;
        logic v;
        logic d;
        logic i;
        logic z;
        logic c;
    } flags_t;

    function automatic byte_t vec_low(kind_e k);
        case (k)
            K_RST:   return VEC_RST_LO;
            K_NMI:   return VEC_NMI_LO;
            default: return VEC_IRQ_LO;
        endcase
    endfunction

    function automatic byte_t pack_status(flags_t f, logic brk);
        byte_t r;
        r        = '0;
        r[P_N]   = f.n;
        r[P_V]   = f.v;
        r[P_ONE] = 1'b1;
        r[P_B]   = brk;
        r[P_D]   = f.d;
        r[P_I]   = f.i;
        r[P_Z]   = f.z;
        r[P_C]   = f.c;
        return r;
    endfunction

    function automatic flags_t unpack_status(byte_t b);
        flags_t f;
        f.n = b[P_N];
        f.v = b[P_V];
        f.d = b[P_D];
        f.i = b[P_I];
        f.z = b[P_Z];
        f.c = b[P_C];
        return f;
    endfunction

    function automatic logic is_push(step_e s);
        return (s == S_PUSH_HI) || (s == S_PUSH_LO) || (s == S_PUSH_P);
    endfunction

endpackage

// File: rtl/ves_nmi_track.sv
module ves_nmi_track (
    input  logic clk,
    input  logic rst,
    input  logic nmi_lvl,
    input  logic pend_clr,
    input  logic irq_exit,
    input  logic idle_boundary,
    output logic nmi_rise,
    output logic nmi_pend,
    output logic nmi_block
);

    logic nmi_q;

    assign nmi_rise = nmi_lvl && !nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q     <= 1'b0;
            nmi_pend  <= 1'b0;
            nmi_block <= 1'b0;
        end else begin
            nmi_q <= nmi_lvl;
            // a fresh edge outranks the clear of an older one
            if (nmi_rise)
                nmi_pend <= 1'b1;
            else if (pend_clr)
                nmi_pend <= 1'b0;
            if (irq_exit)
                nmi_block <= 1'b1;
            else if (idle_boundary)
                nmi_block <= 1'b0;
        end
    end

    // R10: a held level gives no second pending request
    a_r10_level_no_repend: assert property (@(posedge clk) disable iff (rst)
        (nmi_lvl && $past(nmi_lvl) && !nmi_pend) |=> !nmi_pend);

endmodule

// File: rtl/ves_step_ctl.sv
module ves_step_ctl
    import ves_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  insn_boundary,
    input  logic  brk_start,
    input  logic  irq_lvl,
    input  logic  i_flag,
    input  logic  nmi_pend,
    input  logic  nmi_block,
    output step_e step,
    output kind_e kind,
    output kind_e vec
);

    logic  take_nmi;
    logic  take_irq;
    logic  take_brk;
    kind_e pick;

    always_comb begin
        take_nmi = insn_boundary && nmi_pend && !nmi_block;
        take_irq = insn_boundary && irq_lvl && !i_flag;
        take_brk = brk_start;
        if (take_nmi)      pick = K_NMI;
        else if (take_irq) pick = K_IRQ;
        else               pick = K_BRK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= S_FETCH;
            kind <= K_RST;
            vec  <= K_RST;
        end else begin
            case (step)
                S_IDLE: begin
                    if (take_nmi || take_irq || take_brk) begin
                        step <= S_FETCH;
                        kind <= pick;
                        vec  <= pick;
                    end
                end
                S_FETCH:   step <= S_PAD;
                S_PAD:     step <= S_PUSH_HI;
                S_PUSH_HI: step <= S_PUSH_LO;
                S_PUSH_LO: step <= S_PUSH_P;
                S_PUSH_P: begin
                    step <= S_VEC_LO;
                    if (kind != K_RST && nmi_pend)
                        vec <= K_NMI;
                end
                S_VEC_LO:  step <= S_VEC_HI;
                default:   step <= S_IDLE;
            endcase
        end
    end

    // R8: the vector choice is frozen across both vector reads
    a_r8_vec_frozen: assert property (@(posedge clk) disable iff (rst)
        (step == S_VEC_LO) |=> $stable(vec));

    // R1: an entry always runs on to its seventh cycle
    a_r1_no_early_exit: assert property (@(posedge clk) disable iff (rst)
        (step != S_IDLE && step != S_VEC_HI) |=> (step != S_IDLE));

endmodule

// File: rtl/ves_bus_map.sv
module ves_bus_map
    import ves_pkg::*;
(
    input  step_e  step,
    input  kind_e  kind,
    input  kind_e  vec,
    input  addr_t  pc,
    input  byte_t  sp,
    input  flags_t flags,
    output addr_t  addr,
    output logic   rd,
    output logic   wr,
    output byte_t  wdata
);

    addr_t stack_addr;
    addr_t vec_addr;
    logic  resetting;

    always_comb begin
        resetting  = (kind == K_RST);
        stack_addr = {STACK_PAGE, sp};
        vec_addr   = {VEC_PAGE, vec_low(vec) | {7'd0, step == S_VEC_HI}};
        addr       = pc;
        rd         = 1'b0;
        wr         = 1'b0;
        wdata      = '0;
        case (step)
            S_FETCH, S_PAD: begin
                rd = 1'b1;
            end
            S_PUSH_HI, S_PUSH_LO, S_PUSH_P: begin
                addr = stack_addr;
                if (resetting) begin
                    rd = 1'b1;
                end else begin
                    wr = 1'b1;
                    if (step == S_PUSH_HI)
                        wdata = pc[ADDR_W-1:DATA_W];
                    else if (step == S_PUSH_LO)
                        wdata = pc[DATA_W-1:0];
                    else
                        wdata = pack_status(flags, kind == K_BRK);
                end
            end
            S_VEC_LO, S_VEC_HI: begin
                addr = vec_addr;
                rd   = 1'b1;
            end
            default: begin
                addr = pc;
            end
        endcase
    end

endmodule

// File: rtl/vec_entry_seq.sv
module vec_entry_seq
    import ves_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h0000,
    parameter logic [7:0]  SP_SEED  = 8'h00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        insn_boundary,
    input  logic        brk_start,
    input  logic        irq_lvl,
    input  logic        nmi_lvl,
    input  logic        pc_load,
    input  logic [15:0] pc_in,
    input  logic        status_load,
    input  logic [7:0]  status_in,
    input  logic [7:0]  rd_data,
    output logic [15:0] bus_addr,
    output logic        bus_rd,
    output logic        bus_wr,
    output logic [7:0]  bus_wdata,
    output logic        seq_done,
    output logic        seq_busy,
    output logic [15:0] pc_out,
    output logic [7:0]  sp_out,
    output logic [7:0]  status_out
);

    step_e  step;
    kind_e  kind;
    kind_e  vec;
    addr_t  pc;
    byte_t  sp;
    byte_t  vec_lo;
    flags_t flags;
    logic   nmi_rise;
    logic   nmi_pend;
    logic   nmi_block;
    logic   idle;

    assign idle     = (step == S_IDLE);
    assign seq_busy = !idle;
    assign seq_done = (step == S_VEC_HI);

    ves_nmi_track u_nmi (
        .clk           (clk),
        .rst           (rst),
        .nmi_lvl       (nmi_lvl),
        .pend_clr      (seq_done && vec == K_NMI),
        .irq_exit      (seq_done && kind == K_IRQ && vec == K_IRQ),
        .idle_boundary (idle && insn_boundary),
        .nmi_rise      (nmi_rise),
        .nmi_pend      (nmi_pend),
        .nmi_block     (nmi_block)
    );

    ves_step_ctl u_ctl (
        .clk           (clk),
        .rst           (rst),
        .insn_boundary (insn_boundary),
        .brk_start     (brk_start),
        .irq_lvl       (irq_lvl),
        .i_flag        (flags.i),
        .nmi_pend      (nmi_pend),
        .nmi_block     (nmi_block),
        .step          (step),
        .kind          (kind),
        .vec           (vec)
    );

    ves_bus_map u_bus (
        .step  (step),
        .kind  (kind),
        .vec   (vec),
        .pc    (pc),
        .sp    (sp),
        .flags (flags),
        .addr  (bus_addr),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .wdata (bus_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= RESET_PC;
            sp     <= SP_SEED;
            flags  <= '0;
            vec_lo <= '0;
        end else begin
            case (step)
                S_IDLE: begin
                    if (pc_load)
                        pc <= pc_in;
                    if (status_load)
                        flags <= unpack_status(status_in);
                end
                S_FETCH, S_PAD: begin
                    if (kind == K_BRK)
                        pc <= pc + addr_t'(1);
                end
                S_PUSH_HI, S_PUSH_LO, S_PUSH_P: begin
                    sp <= sp - byte_t'(1);
                end
                S_VEC_LO: begin
                    vec_lo <= rd_data;
                end
                default: begin
                    pc      <= {rd_data, vec_lo};
                    flags.i <= 1'b1;
                end
            endcase
        end
    end

    assign pc_out     = pc;
    assign sp_out     = sp;
    assign status_out = pack_status(flags, 1'b0);

    // R1: one access per entry cycle, none while idle
    a_r1_single_access: assert property (@(posedge clk) disable iff (rst)
        seq_busy |-> ($countones({bus_rd, bus_wr}) == 1));

    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !seq_busy |-> (!bus_rd && !bus_wr));

    // R2: the reset entry never writes
    a_r2_reset_reads_only: assert property (@(posedge clk) disable iff (rst)
        (seq_busy && kind == K_RST) |-> !bus_wr);

    // R3: vector reads stay in the top page
    a_r3_vector_page: assert property (@(posedge clk) disable iff (rst)
        (step == S_VEC_LO || step == S_VEC_HI) |-> (bus_addr[15:8] == VEC_PAGE));

    // R4: the stack pointer walks down once per stack cycle
    a_r4_stack_walk: assert property (@(posedge clk) disable iff (rst)
        is_push(step) |=> (sp_out == byte_t'($past(sp_out) - 8'd1)));

    // R6: interrupt-disable is set once an entry completes
    a_r6_iflag_on_exit: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> status_out[P_I]);

    // R13: fixed flag bits
    a_r13_fixed_bits: assert property (@(posedge clk) disable iff (rst)
        (status_out[P_ONE] && !status_out[P_B]));

endmodule

// File: tb/vec_entry_seq_bench.sv
`timescale 1ns/1ps
module vec_entry_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_boundary = 1'b0;
    logic        brk_start = 1'b0;
    logic        irq_lvl = 1'b0;
    logic        nmi_lvl = 1'b0;
    logic        pc_load = 1'b0;
    logic [15:0] pc_in = 16'h0000;
    logic        status_load = 1'b0;
    logic [7:0]  status_in = 8'h00;
    logic [7:0]  rd_data;
    logic [15:0] bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic        seq_done;
    logic        seq_busy;
    logic [15:0] pc_out;
    logic [7:0]  sp_out;
    logic [7:0]  status_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [15:0] c_addr [0:6];
    logic        c_rd   [0:6];
    logic        c_wr   [0:6];
    logic [7:0]  c_wd   [0:6];
    logic        c_done [0:6];
    logic [7:0]  c_stat [0:6];

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        case (a)
            16'hFFFA: return 8'h34;
            16'hFFFB: return 8'h92;
            16'hFFFC: return 8'h00;
            16'hFFFD: return 8'h80;
            16'hFFFE: return 8'h78;
            16'hFFFF: return 8'hA5;
            default:  return a[7:0] ^ a[15:8];
        endcase
    endfunction

    always_comb rd_data = mem_byte(bus_addr);

    vec_entry_seq u_vec_entry_seq (
        .clk           (clk),
        .rst           (rst),
        .insn_boundary (insn_boundary),
        .brk_start     (brk_start),
        .irq_lvl       (irq_lvl),
        .nmi_lvl       (nmi_lvl),
        .pc_load       (pc_load),
        .pc_in         (pc_in),
        .status_load   (status_load),
        .status_in     (status_in),
        .rd_data       (rd_data),
        .bus_addr      (bus_addr),
        .bus_rd        (bus_rd),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .seq_done      (seq_done),
        .seq_busy      (seq_busy),
        .pc_out        (pc_out),
        .sp_out        (sp_out),
        .status_out    (status_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    // records seven entry cycles; nmi_lvl rises in cycle index nmi_at
    task automatic capture(input int nmi_at);
        for (int k = 0; k < 7; k++) begin
            if (k == nmi_at) nmi_lvl = 1'b1;
            c_addr[k] = bus_addr;
            c_rd[k]   = bus_rd;
            c_wr[k]   = bus_wr;
            c_wd[k]   = bus_wdata;
            c_done[k] = seq_done;
            c_stat[k] = status_out;
            tick();
        end
    endtask

    task automatic chk_cyc(input string tag, input int k, input logic exp_wr,
                           input logic [15:0] exp_a, input logic [7:0] exp_d);
        chk({tag, " addr"}, c_addr[k], exp_a);
        chk({tag, " strobes R1"}, {c_rd[k], c_wr[k]}, {!exp_wr, exp_wr});
        if (exp_wr) chk({tag, " wdata"}, c_wd[k], exp_d);
        chk({tag, " done R1"}, c_done[k], (k == 6));
    endtask

    task automatic load_regs(input bit do_pc, input logic [15:0] pcv,
                             input bit do_st, input logic [7:0] stv);
        pc_load = do_pc; pc_in = pcv;
        status_load = do_st; status_in = stv;
        tick();
        pc_load = 1'b0; status_load = 1'b0;
    endtask

    task automatic pulse_boundary;
        insn_boundary = 1'b1;
        tick();
        insn_boundary = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) tick();
        chk("R2 reset pc", pc_out, 16'h0000);
        chk("R2 reset sp", sp_out, 8'h00);
        chk("R2 reset status", status_out, 8'h20);
        chk("R1 reset done low", seq_done, 1'b0);
        rst = 1'b0;
        capture(-1);
        chk_cyc("R2 c0", 0, 1'b0, 16'h0000, 8'h00);
        chk_cyc("R2 c1", 1, 1'b0, 16'h0000, 8'h00);
        chk_cyc("R2 c2", 2, 1'b0, 16'h0100, 8'h00);
        chk_cyc("R2 c3", 3, 1'b0, 16'h01FF, 8'h00);
        chk_cyc("R2 c4", 4, 1'b0, 16'h01FE, 8'h00);
        chk_cyc("R3 rst vec lo", 5, 1'b0, 16'hFFFC, 8'h00);
        chk_cyc("R3 rst vec hi", 6, 1'b0, 16'hFFFD, 8'h00);
        chk("R3 rst pc", pc_out, 16'h8000);
        chk("R2 rst sp", sp_out, 8'hFD);
        chk("R6 rst iflag", status_out, 8'h24);
        chk("R1 idle after", {bus_rd, bus_wr, seq_busy}, 3'b000);
    endtask

    task automatic t_brk;
        load_regs(1'b1, 16'h1234, 1'b1, 8'hDB);
        chk("R13 pc load", pc_out, 16'h1234);
        chk("R13 status load", status_out, 8'hEB);
        load_regs(1'b0, 16'h0000, 1'b1, 8'hC3);
        chk("R13 status load2", status_out, 8'hE3);
        brk_start = 1'b1;
        tick();
        brk_start = 1'b0;
        capture(-1);
        chk_cyc("R4 c0", 0, 1'b0, 16'h1234, 8'h00);
        chk_cyc("R4 c1", 1, 1'b0, 16'h1235, 8'h00);
        chk_cyc("R4 push hi", 2, 1'b1, 16'h01FD, 8'h12);
        chk_cyc("R4 push lo", 3, 1'b1, 16'h01FC, 8'h36);
        chk_cyc("R4 push p", 4, 1'b1, 16'h01FB, 8'hF3);
        chk_cyc("R3 brk vec lo", 5, 1'b0, 16'hFFFE, 8'h00);
        chk_cyc("R3 brk vec hi", 6, 1'b0, 16'hFFFF, 8'h00);
        chk("R6 iflag clear in c5", c_stat[5][2], 1'b0);
        chk("R3 brk pc", pc_out, 16'hA578);
        chk("R4 brk sp", sp_out, 8'hFA);
        chk("R6 brk status", status_out, 8'hE7);
    endtask

    task automatic t_irq_then_nmi;
        irq_lvl = 1'b1;
        pulse_boundary();
        chk("R11 masked irq idle", {seq_busy, bus_rd}, 2'b00);
        load_regs(1'b0, 16'h0000, 1'b1, 8'h00);
        chk("R13 status cleared", status_out, 8'h20);
        pulse_boundary();
        capture(5);
        irq_lvl = 1'b0;
        chk_cyc("R5 irq c0", 0, 1'b0, 16'hA578, 8'h00);
        chk_cyc("R5 irq c1", 1, 1'b0, 16'hA578, 8'h00);
        chk_cyc("R5 irq push hi", 2, 1'b1, 16'h01FA, 8'hA5);
        chk_cyc("R5 irq push lo", 3, 1'b1, 16'h01F9, 8'h78);
        chk_cyc("R5 irq push p", 4, 1'b1, 16'h01F8, 8'h20);
        chk_cyc("R8 irq vec lo", 5, 1'b0, 16'hFFFE, 8'h00);
        chk_cyc("R8 irq vec hi", 6, 1'b0, 16'hFFFF, 8'h00);
        chk("R8 irq pc", pc_out, 16'hA578);
        chk("R11 irq sp", sp_out, 8'hF7);
        pulse_boundary();
        chk("R9 nmi held off", seq_busy, 1'b0);
        pulse_boundary();
        chk("R9 nmi taken next", seq_busy, 1'b1);
        capture(-1);
        chk_cyc("R5 nmi c1", 1, 1'b0, 16'hA578, 8'h00);
        chk_cyc("R5 nmi push hi", 2, 1'b1, 16'h01F7, 8'hA5);
        chk_cyc("R5 nmi push p", 4, 1'b1, 16'h01F5, 8'h24);
        chk_cyc("R3 nmi vec lo", 5, 1'b0, 16'hFFFA, 8'h00);
        chk_cyc("R3 nmi vec hi", 6, 1'b0, 16'hFFFB, 8'h00);
        chk("R3 nmi pc", pc_out, 16'h9234);
        chk("R5 nmi sp", sp_out, 8'hF4);
        pulse_boundary();
        chk("R10 held level no entry", seq_busy, 1'b0);
        nmi_lvl = 1'b0;
        tick();
    endtask

    task automatic t_hijack;
        load_regs(1'b0, 16'h0000, 1'b1, 8'h00);
        brk_start = 1'b1;
        tick();
        brk_start = 1'b0;
        capture(3);
        chk_cyc("R7 c0", 0, 1'b0, 16'h9234, 8'h00);
        chk_cyc("R7 c1", 1, 1'b0, 16'h9235, 8'h00);
        chk_cyc("R7 push hi", 2, 1'b1, 16'h01F4, 8'h92);
        chk_cyc("R7 push lo", 3, 1'b1, 16'h01F3, 8'h36);
        chk_cyc("R7 push p keeps b", 4, 1'b1, 16'h01F2, 8'h30);
        chk_cyc("R7 vec lo", 5, 1'b0, 16'hFFFA, 8'h00);
        chk_cyc("R7 vec hi", 6, 1'b0, 16'hFFFB, 8'h00);
        chk("R7 pc", pc_out, 16'h9234);
        chk("R7 sp", sp_out, 8'hF1);
        nmi_lvl = 1'b0;
        pulse_boundary();
        chk("R10 pending cleared", seq_busy, 1'b0);
    endtask

    task automatic t_priority;
        load_regs(1'b0, 16'h0000, 1'b1, 8'h00);
        nmi_lvl = 1'b1;
        tick();
        insn_boundary = 1'b1; irq_lvl = 1'b1; brk_start = 1'b1;
        tick();
        insn_boundary = 1'b0; brk_start = 1'b0;
        capture(-1);
        chk_cyc("R12 nmi wins c1", 1, 1'b0, 16'h9234, 8'h00);
        chk_cyc("R12 nmi wins p", 4, 1'b1, 16'h01EF, 8'h20);
        chk_cyc("R12 nmi wins vec", 5, 1'b0, 16'hFFFA, 8'h00);
        nmi_lvl = 1'b0;
        load_regs(1'b0, 16'h0000, 1'b1, 8'h00);
        insn_boundary = 1'b1; brk_start = 1'b1;
        tick();
        insn_boundary = 1'b0; brk_start = 1'b0;
        capture(-1);
        irq_lvl = 1'b0;
        chk_cyc("R12 irq over brk c1", 1, 1'b0, 16'h9234, 8'h00);
        chk_cyc("R12 irq over brk p", 4, 1'b1, 16'h01EC, 8'h20);
        chk_cyc("R12 irq over brk vec", 5, 1'b0, 16'hFFFE, 8'h00);
        chk("R12 irq pc", pc_out, 16'hA578);
        chk("R12 irq sp", sp_out, 8'hEB);
    endtask

    task automatic t_rst_mid;
        brk_start = 1'b1;
        tick();
        brk_start = 1'b0;
        tick();
        tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        capture(-1);
        chk_cyc("R12 restart c0", 0, 1'b0, 16'h0000, 8'h00);
        chk_cyc("R12 restart c2", 2, 1'b0, 16'h0100, 8'h00);
        chk_cyc("R12 restart c4", 4, 1'b0, 16'h01FE, 8'h00);
        chk_cyc("R12 restart vec hi", 6, 1'b0, 16'hFFFD, 8'h00);
        chk("R12 restart pc", pc_out, 16'h8000);
        chk("R12 restart sp", sp_out, 8'hFD);
        chk("R6 restart status", status_out, 8'h24);
    endtask

    initial begin
        tick();
        t_reset();
        t_brk();
        t_irq_then_nmi();
        t_hijack();
        t_priority();
        t_rst_mid();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule